// File: doc/BRIEF.md
# Receive Descriptor Pointer Controller

This block holds the current receive-descriptor pointer and the run state of a packet receive DMA engine. Software programs a descriptor list base address through a write port, controls reception with a level enable, and can nudge a suspended engine with a poll-demand strobe. The block asks the bus side to fetch the descriptor at the current pointer. For each fetch, the bus side hands back one ownership bit.

When the engine is running, each descriptor it fetches that the DMA owns is consumed, and the pointer then steps by a fixed descriptor size. A descriptor that the host still owns stops progress. The engine parks in a suspended state and raises a sticky receive-unavailable flag. A poll demand made while suspended re-fetches the same descriptor. If the descriptor is now DMA-owned, running resumes. Otherwise the engine drops back to suspended without touching the flag.

The base address is aligned to the data-bus width by clearing its low bits. It can be written only while the engine is stopped. At the next start the engine takes the new base if one was written; if none was written, it continues from where it stopped.

Top module: `rx_desc_ptr_ctrl`

## Requirements
- R1: After synchronous active-low reset: `rx_state`=0, `cur_ptr`=0, `base_rd`=0, `unavail_flag`=0, `fetch_req`=0.
- R2: A base written while stopped is stored with its low log2(BUS_W/8) bits cleared. This is 3 bits for the default 64-bit bus, so writing 0x12345677 reads back as 0x12345670.
- R3: A base write is accepted only when `rx_state`=0 (stopped) and `rx_enable`=0. In any other cycle, `base_rd` is left unchanged.
- R4: When `rx_enable` is high while stopped, the next cycle has `rx_state`=1 (running). If a base was written since the last start, `cur_ptr` then equals that aligned base.
- R5: A start with no base written since the previous start leaves `cur_ptr` at its value from when reception stopped.
- R6: Whenever `rx_enable` is low, the next cycle has `rx_state`=0. `cur_ptr` is kept.
- R7: In running and poll-fetch states (`rx_state` 1 and 3), `fetch_req`=1 and `fetch_addr`=`cur_ptr`. An acknowledged DMA-owned descriptor (`fetch_host_owned`=0) while running advances `cur_ptr` by DESC_BYTES.
- R8: An acknowledged host-owned descriptor while running moves to `rx_state`=2 (suspended) and sets `unavail_flag`.
- R9: `unavail_flag` is cleared by `unavail_clr`=1. If a set and a clear fall in the same cycle, the set wins.
- R10: A `poll_wr_en` pulse while suspended moves to `rx_state`=3 (poll-fetch) and issues a fetch of the unchanged `cur_ptr`.
- R11: A host-owned reply to a poll fetch returns to `rx_state`=2, leaves `unavail_flag` unchanged, and does not advance `cur_ptr`.
- R12: A DMA-owned reply to a poll fetch returns to `rx_state`=1 without advancing `cur_ptr`.
- R13: `poll_wr_en` has no effect in the stopped, running or poll-fetch states.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_enable | input | 1 | Reception enable level (start/stop) |
| base_wr_en | input | 1 | Base address write strobe |
| base_wr_data | input | ADDR_W | Base address write value |
| poll_wr_en | input | 1 | Poll-demand write strobe |
| fetch_ack | input | 1 | Descriptor fetch completed this cycle |
| fetch_host_owned | input | 1 | Ownership bit of fetched descriptor, 1 = host |
| unavail_clr | input | 1 | Write-one-to-clear for the unavailable flag |
| fetch_req | output | 1 | Descriptor fetch request |
| fetch_addr | output | ADDR_W | Address of descriptor to fetch |
| rx_state | output | 2 | 0 stopped, 1 running, 2 suspended, 3 poll-fetch |
| cur_ptr | output | ADDR_W | Current descriptor pointer |
| base_rd | output | ADDR_W | Stored aligned base address |
| unavail_flag | output | 1 | Sticky receive-unavailable status |

## Verification
A stimulus sampled at a rising edge shows up in `rx_state`, `cur_ptr`, `base_rd` and `unavail_flag` one edge later. `fetch_req` and `fetch_addr` follow combinationally from that new state and pointer, so they change in the same cycle as the state. The bench drives inputs just after each falling edge. Its reference model updates on the rising edge from those inputs, and all six outputs are compared with the model at the following falling edge, so every result is read exactly one register stage after its cause.

// File: rtl/rx_desc_pkg.sv
// Shared types for the receive descriptor pointer controller.
// Assumes: the state encoding is visible at the top-level ports.
package rx_desc_pkg;
    typedef enum logic [1:0] {
        ST_STOP = 2'd0,
        ST_RUN  = 2'd1,
        ST_SUSP = 2'd2,
        ST_POLL = 2'd3
    } rx_state_e;
endpackage

// File: rtl/rx_base_reg.sv
// Base address holding register.
// Stores the aligned base when the write window is open and records that a
// new base is pending for the next start.
// Assumes: wr_open and take are never high together (the FSM guarantees it).
module rx_base_reg #(
    parameter int ADDR_W = 32,
    parameter int BUS_W  = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              wr_open,
    input  logic              take,
    output logic [ADDR_W-1:0] base_q,
    output logic              pend_q
);
    localparam int LOW_BITS = $clog2(BUS_W / 8);
    localparam logic [ADDR_W-1:0] ALIGN_MASK = {ADDR_W{1'b1}} << LOW_BITS;

    // Capture an aligned base on an open write; drop pending once taken.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q <= '0;
            pend_q <= 1'b0;
        end else if (wr_en && wr_open) begin
            base_q <= wr_data & ALIGN_MASK;
            pend_q <= 1'b1;
        end else if (take) begin
            pend_q <= 1'b0;
        end
    end

    AST_BASE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_open |=> $stable(base_q)); // R3
    AST_BASE_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !wr_en) |=> !pend_q); // R4
endmodule

// File: rtl/rx_run_fsm.sv
// Run-state sequencer: stopped / running / suspended / poll-fetch.
// Also owns the sticky receive-unavailable flag.
// Assumes: fetch_ack is meaningful only while fetch_req is high.
module rx_run_fsm
    import rx_desc_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      run,
    input  logic      poll,
    input  logic      ack,
    input  logic      host_owned,
    input  logic      clr,
    output rx_state_e state_q,
    output logic      flag_q,
    output logic      start_evt,
    output logic      step,
    output logic      wr_open,
    output logic      fetch_req
);
    rx_state_e state_d;
    logic      flag_set;

    // Decode the events that other blocks act on.
    always_comb begin
        start_evt = (state_q == ST_STOP) && run;
        wr_open   = (state_q == ST_STOP) && !run;
        step      = (state_q == ST_RUN) && run && ack && !host_owned;
        flag_set  = (state_q == ST_RUN) && run && ack && host_owned;
        fetch_req = (state_q == ST_RUN) || (state_q == ST_POLL);
    end

    // Next-state selection; a low enable stops from any state.
    always_comb begin
        state_d = state_q;
        if (!run) begin
            state_d = ST_STOP;
        end else begin
            case (state_q)
                ST_STOP: state_d = ST_RUN;
                ST_RUN:  if (ack && host_owned) state_d = ST_SUSP;
                ST_SUSP: if (poll) state_d = ST_POLL;
                ST_POLL: if (ack) state_d = host_owned ? ST_SUSP : ST_RUN;
                default: state_d = ST_STOP;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_STOP;
        else        state_q <= state_d;
    end

    // Sticky unavailable flag, set has priority over clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        flag_q <= 1'b0;
        else if (flag_set) flag_q <= 1'b1;
        else if (clr)      flag_q <= 1'b0;
    end

    AST_STOP_ON_DISABLE: assert property (@(posedge clk) disable iff (!rst_n)
        !run |=> state_q == ST_STOP); // R6
    AST_HOST_SUSPENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run && ack && host_owned) |=> (state_q == ST_SUSP && flag_q)); // R8
    AST_POLL_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SUSP && run && poll) |=> state_q == ST_POLL); // R10
    AST_POLL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && run && ack && host_owned && !clr) |=> (state_q == ST_SUSP && $stable(flag_q))); // R11
    AST_POLL_RESUMES: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_POLL && run && ack && !host_owned) |=> state_q == ST_RUN); // R12
    AST_RUN_IGNORES_POLL: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && run && !ack) |=> state_q == ST_RUN); // R13
endmodule

// File: rtl/rx_ptr_unit.sv
// Current descriptor pointer.
// On start loads the pending base, otherwise keeps its value; steps by one
// descriptor each time a DMA-owned descriptor is consumed.
// Assumes: DESC_BYTES is a multiple of the bus width in bytes.
module rx_ptr_unit #(
    parameter int ADDR_W     = 32,
    parameter int BUS_W      = 64,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_evt,
    input  logic              base_pend,
    input  logic [ADDR_W-1:0] base_val,
    input  logic              step,
    output logic [ADDR_W-1:0] ptr_q
);
    localparam int LOW_BITS = $clog2(BUS_W / 8);
    localparam logic [ADDR_W-1:0] STEP_VAL = ADDR_W'(DESC_BYTES);

    // Load on start with a new base, advance on consume.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (start_evt) begin
            if (base_pend) ptr_q <= base_val;
        end else if (step) begin
            ptr_q <= ptr_q + STEP_VAL;
        end
    end

    AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (step && !start_evt) |=> ptr_q == $past(ptr_q) + STEP_VAL); // R7
    AST_PTR_RESUME: assert property (@(posedge clk) disable iff (!rst_n)
        (start_evt && !base_pend) |=> $stable(ptr_q)); // R5
    AST_PTR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_q[LOW_BITS-1:0] == '0); // R2
endmodule

// File: rtl/rx_desc_ptr_ctrl.sv
// Receive descriptor pointer controller, top level.
// Ties together the base register, run sequencer and pointer unit.
// Assumes: a single fetch is outstanding at a time and fetch_ack is a
// one-cycle pulse qualified by fetch_req.
module rx_desc_ptr_ctrl #(
    parameter int ADDR_W     = 32,
    parameter int BUS_W      = 64,
    parameter int DESC_BYTES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_enable,
    input  logic              base_wr_en,
    input  logic [ADDR_W-1:0] base_wr_data,
    input  logic              poll_wr_en,
    input  logic              fetch_ack,
    input  logic              fetch_host_owned,
    input  logic              unavail_clr,
    output logic              fetch_req,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic [1:0]        rx_state,
    output logic [ADDR_W-1:0] cur_ptr,
    output logic [ADDR_W-1:0] base_rd,
    output logic              unavail_flag
);
    import rx_desc_pkg::*;

    rx_state_e st;
    logic      start_evt, step, wr_open, pend;

    rx_run_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .run        (rx_enable),
        .poll       (poll_wr_en),
        .ack        (fetch_ack),
        .host_owned (fetch_host_owned),
        .clr        (unavail_clr),
        .state_q    (st),
        .flag_q     (unavail_flag),
        .start_evt  (start_evt),
        .step       (step),
        .wr_open    (wr_open),
        .fetch_req  (fetch_req)
    );

    rx_base_reg #(.ADDR_W(ADDR_W), .BUS_W(BUS_W)) u_base (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (base_wr_en),
        .wr_data (base_wr_data),
        .wr_open (wr_open),
        .take    (start_evt),
        .base_q  (base_rd),
        .pend_q  (pend)
    );

    rx_ptr_unit #(.ADDR_W(ADDR_W), .BUS_W(BUS_W), .DESC_BYTES(DESC_BYTES)) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_evt (start_evt),
        .base_pend (pend),
        .base_val  (base_rd),
        .step      (step),
        .ptr_q     (cur_ptr)
    );

    // Present the state and fetch address at the ports.
    always_comb begin
        rx_state   = st;
        fetch_addr = cur_ptr;
    end

    AST_FETCH_IN_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
        fetch_req |-> (rx_state == 2'd1 || rx_state == 2'd3)); // R7
    AST_STOP_KEEPS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_state != 2'd0 && !rx_enable) |=> $stable(cur_ptr)); // R6
endmodule

// File: tb/sim_rx_desc_ptr_ctrl.sv
// Bench: behavioural reference model compared on every falling edge.
module sim_rx_desc_ptr_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_enable = 1'b0, base_wr_en = 1'b0, poll_wr_en = 1'b0;
    logic        fetch_ack = 1'b0, fetch_host_owned = 1'b0, unavail_clr = 1'b0;
    logic [31:0] base_wr_data = '0;
    logic        fetch_req, unavail_flag;
    logic [31:0] fetch_addr, cur_ptr, base_rd;
    logic [1:0]  rx_state;

    int    n_chk = 0, n_bad = 0;
    string tag = "R1";

    // model state
    int          m_st = 0;
    logic [31:0] m_ptr = 0, m_base = 0;
    bit          m_pend = 0, m_flag = 0;

    always #2.5 clk = ~clk;

    rx_desc_ptr_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .base_wr_en(base_wr_en),
        .base_wr_data(base_wr_data), .poll_wr_en(poll_wr_en), .fetch_ack(fetch_ack),
        .fetch_host_owned(fetch_host_owned), .unavail_clr(unavail_clr),
        .fetch_req(fetch_req), .fetch_addr(fetch_addr), .rx_state(rx_state),
        .cur_ptr(cur_ptr), .base_rd(base_rd), .unavail_flag(unavail_flag)
    );

    // Reference model: 0 stop, 1 run, 2 suspended, 3 poll fetch.
    always @(posedge clk) begin
        int nst;
        if (!rst_n) begin
            m_st = 0; m_ptr = 0; m_base = 0; m_pend = 0; m_flag = 0;
        end else begin
            nst = m_st;
            if (m_st == 0 && !rx_enable && base_wr_en) begin
                m_base = {base_wr_data[31:3], 3'b000};
                m_pend = 1;
            end
            if (!rx_enable) nst = 0;
            else if (m_st == 0) begin
                nst = 1;
                if (m_pend) m_ptr = m_base;
                m_pend = 0;
            end else if (m_st == 1 && fetch_ack) begin
                if (fetch_host_owned) begin nst = 2; m_flag = 1; end
                else m_ptr = m_ptr + 32'd16;
            end else if (m_st == 2 && poll_wr_en) nst = 3;
            else if (m_st == 3 && fetch_ack) nst = fetch_host_owned ? 2 : 1;
            if (unavail_clr && !(m_st == 1 && rx_enable && fetch_ack && fetch_host_owned))
                m_flag = 0;
            m_st = nst;
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    // Compare all outputs on every falling edge.
    always @(negedge clk) begin
        if (rst_n || tag == "R1") begin
            chk("rx_state", 32'(rx_state), 32'(m_st));
            chk("cur_ptr", cur_ptr, m_ptr);
            chk("base_rd", base_rd, m_base);
            chk("unavail_flag", 32'(unavail_flag), 32'(m_flag));
            chk("fetch_req", 32'(fetch_req), 32'(m_st == 1 || m_st == 3));
            chk("fetch_addr", fetch_addr, m_ptr);
        end
    end

    // Drive inputs right after the compare at the falling edge.
    task automatic cyc(int n = 1);
        repeat (n) @(negedge clk);
        #0.1;
        base_wr_en = 0; poll_wr_en = 0; fetch_ack = 0; unavail_clr = 0;
    endtask

    initial begin
        #1000000;
        n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        cyc(3);
        rst_n = 1; tag = "R1"; cyc(2);
        // R2 alignment, R4 start loads base
        tag = "R2"; base_wr_en = 1; base_wr_data = 32'h1234_5677; cyc();
        tag = "R13"; poll_wr_en = 1; cyc(2);
        tag = "R4"; rx_enable = 1; cyc(2);
        // R7 consume two DMA-owned descriptors
        tag = "R7"; fetch_ack = 1; fetch_host_owned = 0; cyc();
        fetch_ack = 1; cyc(2);
        // R3 write while running ignored, R13 poll in run ignored
        tag = "R3"; base_wr_en = 1; base_wr_data = 32'hDEAD_BEEF; cyc(2);
        tag = "R13"; poll_wr_en = 1; cyc(2);
        // R8 host-owned suspends and flags
        tag = "R8"; fetch_ack = 1; fetch_host_owned = 1; cyc(2);
        tag = "R9"; unavail_clr = 1; cyc(2);
        // R10/R11 poll finds host-owned
        tag = "R10"; poll_wr_en = 1; cyc(2);
        tag = "R11"; fetch_ack = 1; fetch_host_owned = 1; cyc(2);
        // R10/R12 poll finds DMA-owned
        tag = "R10"; poll_wr_en = 1; cyc();
        tag = "R13"; poll_wr_en = 1; cyc();
        tag = "R12"; fetch_ack = 1; fetch_host_owned = 0; cyc(2);
        // R9 set and clear together: set wins
        tag = "R9"; fetch_ack = 1; fetch_host_owned = 1; unavail_clr = 1; cyc(2);
        // R6 stop, R5 resume
        tag = "R6"; rx_enable = 0; cyc(3);
        tag = "R3"; rx_enable = 1; base_wr_en = 1; base_wr_data = 32'h0000_4000; cyc(2);
        tag = "R5"; cyc(2);
        tag = "R6"; rx_enable = 0; cyc(2);
        tag = "R4"; base_wr_en = 1; base_wr_data = 32'h0000_8008; cyc();
        base_wr_en = 1; base_wr_data = 32'h0000_9F0F; cyc();
        rx_enable = 1; cyc(3);
        // Mixed traffic
        tag = "R7";
        for (int i = 0; i < 4000; i++) begin
            rx_enable = ($urandom_range(0, 19) != 0);
            base_wr_en = $urandom_range(0, 3) == 0;
            base_wr_data = $urandom;
            poll_wr_en = $urandom_range(0, 2) == 0;
            fetch_ack = $urandom_range(0, 1);
            fetch_host_owned = $urandom_range(0, 2) == 0;
            unavail_clr = $urandom_range(0, 4) == 0;
            @(negedge clk); #0.1;
        end
        cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule